// File: doc/BRIEF.md
# Per-Lane Bit Counter

This block takes a 128-bit vector, splits it into equal lanes of 8, 16, 32 or 64 bits, and computes one count per lane. It can count the set bits, the run of zero bits from the top of the lane, or the run of one bits from the top of the lane. Each count is zero-extended and written into the lane of the result that has the same position and width as the source lane. The lanes are computed independently, so a lane's result depends only on the bits inside that lane.

A vector-unit decoder drives it with a lane-format code, a count-operation code, the source vector and the destination register index. One clock after an accepted request the block presents the result with a one-cycle valid pulse. When write tracking is enabled for the request, the block also sets the bit for the destination index in a sticky modify mask. A reserved operation code is rejected with a one-cycle flag and changes nothing.

Top module: `lane_count_unit`

## Requirements
- R1: `fmt` selects the lane width as 8 shifted left by its value: 0 gives 16 byte lanes, 1 gives 8 halfword lanes, 2 gives 4 word lanes and 3 gives 2 doubleword lanes. Lane k takes bits [k*W+W-1 : k*W].
- R2: `op` selects the count: 0 is set-bit count, 1 is leading-ones count, 2 is leading-zeros count and 3 is reserved.
- R3: For op 0, each result lane holds the number of set bits in the matching source lane.
- R4: For op 2, each result lane holds the number of consecutive zero bits from the lane's top bit down; an all-zero lane gives the lane width.
- R5: For op 1, each result lane holds the number of consecutive one bits from the lane's top bit down; an all-ones lane gives the lane width.
- R6: Each count is zero-extended to fill its own lane, and a lane's result does not depend on bits of any other lane.
- R7: The result appears, with `out_valid` high for exactly one cycle, on the clock edge after `in_valid` is high with a non-reserved op; `out_valid` is low in all other cycles.
- R8: A request with op 3 raises `out_bad_op` for one cycle on the next edge, keeps `out_valid` low and leaves `result` and `modify_mask` unchanged.
- R9: An accepted request with `track_en` high sets bit `dst_idx` of `modify_mask`; with `track_en` low the mask is unchanged; set bits stay set until reset.
- R10: After reset `result`, `modify_mask`, `out_valid` and `out_bad_op` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Lane-format code (R1) |
| op | input | 2 | Count-operation code (R2) |
| src | input | 128 | Source vector |
| dst_idx | input | 5 | Destination register index for mask tracking |
| track_en | input | 1 | Enables modify-mask update for this request |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_bad_op | output | 1 | One-cycle pulse marking a rejected reserved op |
| result | output | 128 | Registered per-lane counts |
| modify_mask | output | 32 | Sticky per-register modify mask |

## Verification
The bench targets all-zero and all-ones lanes, where a leading-bit counter that stops its search one step early reports the width minus one instead of the full width. It places a lone full lane beside empty ones, which exposes a design that lets a count spill into a neighbouring lane or takes bits beyond the lane width. It feeds the same source under every format, so a swapped format decode produces lanes of the wrong size, and it sends the reserved op with tracking on, which catches a design that still writes the result or marks the mask.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

  typedef enum logic [1:0] {
    OP_POP    = 2'd0,
    OP_LONES  = 2'd1,
    OP_LZEROS = 2'd2,
    OP_RSVD   = 2'd3
  } cnt_op_e;

  // Mask keeping the low w bits of a 64-bit word.
  function automatic logic [63:0] f_low_mask(input int unsigned w);
    if (w >= 64) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  // Mask selecting the lower group of each pair at tree level lvl.
  function automatic logic [63:0] f_group_mask(input int unsigned lvl);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = ((i >> lvl) & 1) == 0;
    return m;
  endfunction

  // Set-bit count by adding neighbouring groups of 1,2,4,8,16,32 bits.
  function automatic logic [6:0] f_popcount(input logic [63:0] x, input int unsigned w);
    logic [63:0] v;
    logic [63:0] m;
    v = x & f_low_mask(w);
    for (int lvl = 0; lvl < 6; lvl++) begin
      m = f_group_mask(lvl);
      v = (v & m) + ((v >> (1 << lvl)) & m);
    end
    return v[6:0];
  endfunction

  // Leading-zero count over the low w bits by halving binary search.
  function automatic logic [6:0] f_lead_zeros(input logic [63:0] x, input int unsigned w);
    logic [63:0] v;
    logic [63:0] y;
    logic [6:0]  n;
    logic [6:0]  c;
    v = x & f_low_mask(w);
    n = 7'(w);
    c = 7'(w >> 1);
    for (int k = 0; k < 6; k++) begin
      if (c != 7'd0) begin
        y = v >> c;
        if (y != 64'd0) begin
          n = n - c;
          v = y;
        end
        c = c >> 1;
      end
    end
    return n - {6'd0, v[0]};
  endfunction

endpackage

// File: rtl/lcu_lane.sv
module lcu_lane
  import lcu_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [1:0]        op,
  output logic [LANE_W-1:0] lane_out
);

  localparam int unsigned CNT_W = 7;

  logic [63:0]      lane_wide;
  logic [63:0]      lane_inv;
  logic [CNT_W-1:0] pop_cnt;
  logic [CNT_W-1:0] lz_cnt;
  logic [CNT_W-1:0] lo_cnt;
  logic [CNT_W-1:0] sel_cnt;

  assign lane_wide = 64'(lane_in);
  // Leading ones reuse the leading-zero search on the inverted lane.
  assign lane_inv  = 64'(~lane_in);
  assign pop_cnt   = f_popcount(lane_wide, LANE_W);
  assign lz_cnt    = f_lead_zeros(lane_wide, LANE_W);
  assign lo_cnt    = f_lead_zeros(lane_inv, LANE_W);

  always_comb begin
    case (cnt_op_e'(op))
      OP_POP:    sel_cnt = pop_cnt;
      OP_LONES:  sel_cnt = lo_cnt;
      OP_LZEROS: sel_cnt = lz_cnt;
      default:   sel_cnt = '0;
    endcase
  end

  // Zero-extend the count into the lane (R6).
  assign lane_out = {{(LANE_W-CNT_W){1'b0}}, sel_cnt};

  // Leading runs never exceed the lane width (R4, R5).
  always_comb begin
    if (!$isunknown(lane_in)) begin
      p_run_range_r4: assert (lz_cnt <= CNT_W'(LANE_W) && lo_cnt <= CNT_W'(LANE_W));
      // Top bit is either 0 or 1, so one of the two runs must be empty (R5).
      p_one_run_empty_r5: assert (lz_cnt == '0 || lo_cnt == '0);
      p_pop_range_r3: assert (pop_cnt <= CNT_W'(LANE_W));
    end
  end

endmodule

// File: rtl/lcu_width_bank.sv
module lcu_width_bank #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0] src,
  input  logic [1:0]       op,
  output logic [VEC_W-1:0] res
);

  localparam int unsigned N_LANES = VEC_W / LANE_W;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    lcu_lane #(.LANE_W(LANE_W)) u_lane (
      .lane_in  (src[k*LANE_W +: LANE_W]),
      .op       (op),
      .lane_out (res[k*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/lane_count_unit.sv
module lane_count_unit
  import lcu_pkg::*;
#(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned REG_CNT = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 fmt,
  input  logic [1:0]                 op,
  input  logic [VEC_W-1:0]           src,
  input  logic [$clog2(REG_CNT)-1:0] dst_idx,
  input  logic                       track_en,
  output logic                       out_valid,
  output logic                       out_bad_op,
  output logic [VEC_W-1:0]           result,
  output logic [REG_CNT-1:0]         modify_mask
);

  localparam int unsigned N_FMT = 4;
  localparam int unsigned IDX_W = $clog2(REG_CNT);

  logic [VEC_W-1:0] bank_res [N_FMT];
  logic [VEC_W-1:0] result_next;
  logic             accept_fire;
  logic             reject_fire;
  logic             mark_fire;

  // One bank of lane engines per lane width (R1).
  for (genvar f = 0; f < N_FMT; f++) begin : g_bank
    lcu_width_bank #(.VEC_W(VEC_W), .LANE_W(8 << f)) u_bank (
      .src (src),
      .op  (op),
      .res (bank_res[f])
    );
  end

  assign result_next = bank_res[fmt];
  assign accept_fire = in_valid && (cnt_op_e'(op) != OP_RSVD);
  assign reject_fire = in_valid && (cnt_op_e'(op) == OP_RSVD);
  assign mark_fire   = accept_fire && track_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_bad_op  <= 1'b0;
      result      <= '0;
      modify_mask <= '0;
    end else begin
      out_valid  <= accept_fire;
      out_bad_op <= reject_fire;
      if (accept_fire) result <= result_next;
      if (mark_fire) modify_mask[dst_idx] <= 1'b1;
    end
  end

  p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 2'd3) |=> (out_valid && !out_bad_op));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_bad_op));

  p_reject_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=> (out_bad_op && !out_valid && $stable(result) && $stable(modify_mask)));

  p_mask_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 2'd3 && track_en) |=> modify_mask[$past(dst_idx)]);

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 2'd3 && !track_en) |=> $stable(modify_mask));

  p_mask_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(modify_mask) & ~modify_mask) == '0));

  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_bad_op));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  logic unused_idx_w;
  assign unused_idx_w = (IDX_W == 0);

endmodule

// File: tb/lane_count_unit_tb.sv
module lane_count_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   fmt = '0;
  logic [1:0]   op = '0;
  logic [127:0] src = '0;
  logic [4:0]   dst_idx = '0;
  logic         track_en = 1'b0;
  logic         out_valid;
  logic         out_bad_op;
  logic [127:0] result;
  logic [31:0]  modify_mask;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_count_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .op(op),
    .src(src), .dst_idx(dst_idx), .track_en(track_en),
    .out_valid(out_valid), .out_bad_op(out_bad_op),
    .result(result), .modify_mask(modify_mask)
  );

  // {fmt, op, src}
  localparam logic [131:0] VECS [12] = '{
    {2'd0, 2'd0, 128'h0123456789abcdef_fedcba9876543210},
    {2'd1, 2'd0, 128'h0123456789abcdef_fedcba9876543210},
    {2'd2, 2'd0, 128'hffffffff00000000_8000000100ff00ff},
    {2'd3, 2'd0, 128'h0123456789abcdef_ffffffffffffffff},
    {2'd0, 2'd2, 128'h0102040810204080_00ff7f3f1f0f0703},
    {2'd1, 2'd2, 128'h0001000280004000_0000ffff00100800},
    {2'd2, 2'd2, 128'h0000000100010000_8000000000000000},
    {2'd3, 2'd2, 128'h0000000000000001_00000000ffffffff},
    {2'd0, 2'd1, 128'hfffefcf8f0e0c080_ff007fbfdfeff7fb},
    {2'd1, 2'd1, 128'hfffe8000c000ffff_0000fff0e0017fff},
    {2'd2, 2'd1, 128'hffffffff80000000_fffffffe7fffffff},
    {2'd3, 2'd1, 128'hfffffffffffffffe_f000000000000000}
  };

  function automatic logic [127:0] m_result(logic [1:0] f, logic [1:0] o, logic [127:0] s);
    int w;
    int lanes;
    int cnt;
    int base;
    bit stop;
    logic want;
    logic [127:0] r;
    w = 8 << f;
    lanes = 128 / w;
    r = '0;
    want = (o == 2'd1);
    for (int l = 0; l < lanes; l++) begin
      cnt = 0;
      base = l * w;
      stop = 1'b0;
      if (o == 2'd0) begin
        for (int b = 0; b < w; b++) if (s[base+b]) cnt++;
      end else begin
        for (int b = w - 1; b >= 0; b--) begin
          if (s[base+b] != want) stop = 1'b1;
          if (!stop) cnt++;
        end
      end
      for (int b = 0; b < 32; b++) if (b < w) r[base+b] = cnt[b];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [1:0] f, logic [1:0] o, logic [127:0] s, logic [4:0] d, logic te);
    @(negedge clk);
    in_valid = 1'b1; fmt = f; op = o; src = s; dst_idx = d; track_en = te;
    @(negedge clk);
    in_valid = 1'b0; track_en = 1'b0;
  endtask

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 result", result, '0);
    check("R10 mask", 128'(modify_mask), '0);
    check("R10 flags", 128'({out_valid, out_bad_op}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 format, R2 op decode, R3/R4/R5 counts
    for (int i = 0; i < 12; i++) begin
      issue(VECS[i][131:130], VECS[i][129:128], VECS[i][127:0], 5'd0, 1'b0);
      case (VECS[i][129:128])
        2'd0: check("R1 R2 R3 popcount", result, m_result(VECS[i][131:130], 2'd0, VECS[i][127:0]));
        2'd1: check("R1 R2 R5 lead ones", result, m_result(VECS[i][131:130], 2'd1, VECS[i][127:0]));
        default: check("R1 R2 R4 lead zeros", result, m_result(VECS[i][131:130], 2'd2, VECS[i][127:0]));
      endcase
      check("R7 valid pulse", 128'(out_valid), 128'd1);
    end

    // R7: valid is a single pulse
    @(negedge clk);
    check("R7 valid low after", 128'(out_valid), 128'd0);

    // R4: all-zero doubleword lanes
    issue(2'd3, 2'd2, '0, 5'd0, 1'b0);
    check("R4 zero lane width", result, {64'd64, 64'd64});
    // R5: all-ones byte lanes
    issue(2'd0, 2'd1, '1, 5'd0, 1'b0);
    check("R5 ones lane width", result, {16{8'h08}});
    // R3: all-ones halfword popcount
    issue(2'd1, 2'd0, '1, 5'd0, 1'b0);
    check("R3 full halfwords", result, {8{16'h0010}});
    // R6: lone full byte beside empty lanes
    issue(2'd0, 2'd0, 128'hff, 5'd0, 1'b0);
    check("R6 lane isolation", result, 128'h08);
    // R6: same source, word lanes, leading zeros
    issue(2'd2, 2'd2, 128'h000000ff_00000000_00000001_ffffffff, 5'd0, 1'b0);
    check("R6 word lanes", result, {32'd24, 32'd32, 32'd31, 32'd0});

    // R9: mask tracking
    issue(2'd0, 2'd0, '0, 5'd5, 1'b1);
    check("R9 mark bit", 128'(modify_mask), 128'h20);
    issue(2'd0, 2'd0, '0, 5'd7, 1'b0);
    check("R9 untracked hold", 128'(modify_mask), 128'h20);
    issue(2'd1, 2'd2, '0, 5'd31, 1'b1);
    check("R9 sticky mark", 128'(modify_mask), 128'h8000_0020);

    // R8: reserved op
    held = result;
    issue(2'd0, 2'd3, '1, 5'd9, 1'b1);
    check("R8 bad flag", 128'({out_bad_op, out_valid}), 128'b10);
    check("R8 result held", result, held);
    check("R8 mask held", 128'(modify_mask), 128'h8000_0020);
    @(negedge clk);
    check("R8 flag pulse", 128'(out_bad_op), 128'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog got=hung exp=done");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule